// File: doc/BRIEF.md
# Dual Accumulator Partial-Load Unit

This block keeps two 36-bit accumulators. Each one has a 32-bit body with four guard bits above it. It carries out register-to-accumulator move commands. A short move writes one 16-bit half of the chosen accumulator from a 16-bit source. If the source is narrower than 16 bits, it is first widened by sign or by zero. Loading the upper half rewrites the guard bits from bit 31, and it can also zero the lower half. A long move copies a 32-bit product-style value into the accumulator, sign-extended to 36 bits. It finishes in one cycle and updates the arithmetic flags.

A short move takes two cycles. The command is captured on the first edge, and `busy` is high for the cycle that follows. The accumulator is written on the second edge, and the flags do not change. Any command that arrives while `busy` is high is dropped. Instruction decoding, the register file and the ALU sit outside this block.

Top module: `acc_load_unit`

## Requirements
- R1: A synchronous active-high reset clears both accumulators and the N, Z and V flags to zero, and drives `busy` low.
- R2: `acc_sel` = 0 addresses accumulator a1 (`acc1_q`), and 1 addresses a0 (`acc0_q`). `half_sel` = 0 writes bits 31:16, and 1 writes bits 15:0.
- R3: An upper-half write with `clr_lo_en` = 0 keeps bits 15:0. In every case it sets bits 35:32 to copies of the new bit 31.
- R4: An upper-half write with `clr_lo_en` = 1 zeroes bits 15:0. On a lower-half write, `clr_lo_en` has no effect.
- R5: A lower-half write leaves bits 35:16 of the target unchanged. The other accumulator is never touched by a short move.
- R6: With `src_narrow` = 1, only `src_data[7:0]` is used. It is extended to 16 bits with copies of bit 7 when `src_sext` = 1, and with zeros when `src_sext` = 0.
- R7: A short move accepted on edge k raises `busy` for exactly one cycle after k. It writes the accumulator on edge k+1 and leaves the flags unchanged.
- R8: A command presented while `busy` is high is ignored. It does not change any accumulator and does not extend `busy`.
- R9: A long move (`long_move` = 1) writes `{4{long_data[31]}, long_data}` into the selected accumulator on the accepting edge. `half_sel` and `clr_lo_en` are ignored, and `busy` stays low.
- R10: On a long move, the flags are registered on the same edge. N is bit 35 of the new value. Z is set when all 36 bits are zero. V is set when the guard bits differ from bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| acc_sel | input | 1 | 0 selects a1, 1 selects a0 |
| half_sel | input | 1 | 0 upper half, 1 lower half |
| src_data | input | 16 | Short-move source value |
| src_narrow | input | 1 | Source is 8 bits wide |
| src_sext | input | 1 | Sign-extend a narrow source |
| clr_lo_en | input | 1 | Zero lower half on upper write |
| long_move | input | 1 | Use the 32-bit one-cycle path |
| long_data | input | 32 | Long-move source value |
| acc0_q | output | 36 | Accumulator a0 |
| acc1_q | output | 36 | Accumulator a1 |
| busy | output | 1 | Short move in progress |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions assume that control inputs are known at every clock edge once reset is released. They also assume that `long_data` and `src_data` are steady around the edge that samples them. The bench meets this by driving every input on the falling edge and holding it for a full cycle. It drops `cmd_valid` again before the next command, except in the test that presents a command while `busy` is high on purpose.

// File: rtl/acc_pkg.sv
package acc_pkg;
  parameter int HALF_W   = 16;
  parameter int GUARD_W  = 4;
  parameter int BODY_W   = 2 * HALF_W;
  parameter int ACC_W    = BODY_W + GUARD_W;
  parameter int NARROW_W = 8;
  parameter int N_ACC    = 2;

  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;
endpackage

// File: rtl/acc_src_ext.sv
module acc_src_ext #(
  parameter int HALF_W   = acc_pkg::HALF_W,
  parameter int NARROW_W = acc_pkg::NARROW_W
) (
  input  logic [HALF_W-1:0] raw,
  input  logic              narrow,
  input  logic              sext,
  output logic [HALF_W-1:0] val
);
  localparam int PAD_W = HALF_W - NARROW_W;

  always_comb begin
    if (narrow)
      val = {{PAD_W{sext & raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
    else
      val = raw;
  end
endmodule

// File: rtl/acc_cmd_ctrl.sv
module acc_cmd_ctrl
  import acc_pkg::*;
#(
  parameter int HALF_W = acc_pkg::HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              long_move,
  input  logic              acc_sel,
  input  logic              half_sel,
  input  logic              clr_en,
  input  logic [HALF_W-1:0] ext_val,
  output logic              busy,
  output logic              long_go,
  output logic              pend_idx,
  output half_e             pend_half,
  output logic              pend_clr,
  output logic [HALF_W-1:0] pend_data
);
  logic accept_short;

  assign accept_short = cmd_valid && !long_move && !busy;
  assign long_go      = cmd_valid &&  long_move && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pend_idx  <= 1'b0;
      pend_half <= HALF_UPPER;
      pend_clr  <= 1'b0;
      pend_data <= '0;
    end else if (busy) begin
      busy <= 1'b0;
    end else if (accept_short) begin
      busy      <= 1'b1;
      pend_idx  <= ~acc_sel;
      pend_half <= half_e'(half_sel);
      pend_clr  <= clr_en;
      pend_data <= ext_val;
    end
  end

  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R8
  AST_SHORT_ARMS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !long_move && !busy) |=> busy); // R7
  AST_LONG_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && long_move && !busy) |=> !busy); // R9
endmodule

// File: rtl/acc_reg_slice.sv
module acc_reg_slice #(
  parameter int HALF_W  = acc_pkg::HALF_W,
  parameter int GUARD_W = acc_pkg::GUARD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic                clr_lo,
  input  logic [HALF_W-1:0]   half_data,
  input  logic                wr_long,
  input  logic [2*HALF_W-1:0] long_data,
  output logic [2*HALF_W+GUARD_W-1:0] acc
);
  localparam int BODY_W = 2 * HALF_W;
  localparam int ACC_W  = BODY_W + GUARD_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (wr_long) begin
      acc <= {{GUARD_W{long_data[BODY_W-1]}}, long_data};
    end else if (wr_hi) begin
      acc[ACC_W-1:BODY_W]  <= {GUARD_W{half_data[HALF_W-1]}};
      acc[BODY_W-1:HALF_W] <= half_data;
      if (clr_lo) acc[HALF_W-1:0] <= '0;
    end else if (wr_lo) begin
      acc[HALF_W-1:0] <= half_data;
    end
  end

  AST_GUARD_COPY: assert property (@(posedge clk) disable iff (rst)
    (wr_hi || wr_long) |=> (acc[ACC_W-1:BODY_W] == {GUARD_W{acc[BODY_W-1]}})); // R3
  AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && clr_lo && !wr_long) |=> (acc[HALF_W-1:0] == '0)); // R4
  AST_LOW_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi && !wr_long) |=> $stable(acc[ACC_W-1:HALF_W])); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo && !wr_hi && !wr_long) |=> $stable(acc)); // R8
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit #(
  parameter int ACC_W   = acc_pkg::ACC_W,
  parameter int GUARD_W = acc_pkg::GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [ACC_W-1:0] new_val,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v
);
  localparam int BODY_W = ACC_W - GUARD_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
    end else if (upd) begin
      flag_n <= new_val[ACC_W-1];
      flag_z <= (new_val == '0);
      flag_v <= (new_val[ACC_W-1:BODY_W] != {GUARD_W{new_val[BODY_W-1]}});
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable({flag_n, flag_z, flag_v})); // R7
  AST_FLAGS_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    upd |=> !(flag_n && flag_z)); // R10
endmodule

// File: rtl/acc_load_unit.sv
module acc_load_unit
  import acc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic                acc_sel,
  input  logic                half_sel,
  input  logic [HALF_W-1:0]   src_data,
  input  logic                src_narrow,
  input  logic                src_sext,
  input  logic                clr_lo_en,
  input  logic                long_move,
  input  logic [BODY_W-1:0]   long_data,
  output logic [ACC_W-1:0]    acc0_q,
  output logic [ACC_W-1:0]    acc1_q,
  output logic                busy,
  output logic                flag_n,
  output logic                flag_z,
  output logic                flag_v
);
  logic [HALF_W-1:0] ext_val;
  logic              long_go;
  logic              pend_idx;
  half_e             pend_half;
  logic              pend_clr;
  logic [HALF_W-1:0] pend_data;
  logic              long_idx;
  logic [ACC_W-1:0]  acc_bank [N_ACC];
  logic [ACC_W-1:0]  long_ext;

  assign long_idx = ~acc_sel;
  assign long_ext = {{GUARD_W{long_data[BODY_W-1]}}, long_data};

  acc_src_ext #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_ext (
    .raw(src_data), .narrow(src_narrow), .sext(src_sext), .val(ext_val)
  );

  acc_cmd_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .long_move(long_move),
    .acc_sel(acc_sel), .half_sel(half_sel), .clr_en(clr_lo_en),
    .ext_val(ext_val), .busy(busy), .long_go(long_go),
    .pend_idx(pend_idx), .pend_half(pend_half), .pend_clr(pend_clr),
    .pend_data(pend_data)
  );

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    logic hit_short, hit_long;
    assign hit_short = busy && (pend_idx == 1'(i));
    assign hit_long  = long_go && (long_idx == 1'(i));

    acc_reg_slice #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_slice (
      .clk(clk), .rst(rst),
      .wr_hi(hit_short && pend_half == HALF_UPPER),
      .wr_lo(hit_short && pend_half == HALF_LOWER),
      .clr_lo(pend_clr), .half_data(pend_data),
      .wr_long(hit_long), .long_data(long_data),
      .acc(acc_bank[i])
    );
  end

  assign acc0_q = acc_bank[0];
  assign acc1_q = acc_bank[1];

  acc_flag_unit #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_flags (
    .clk(clk), .rst(rst), .upd(long_go), .new_val(long_ext),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  AST_NEG_TRACKS_ACC: assert property (@(posedge clk) disable iff (rst)
    (long_go && acc_sel) |=> (flag_n == acc0_q[ACC_W-1])); // R10
  AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (rst)
    (long_go && !acc_sel) |=> (flag_z == (acc1_q == '0))); // R10
  AST_LONG_OTHER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (long_go && acc_sel && !busy) |=> $stable(acc1_q)); // R9
endmodule

// File: tb/tb_acc_load_unit.sv
module tb_acc_load_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, acc_sel, half_sel, src_narrow, src_sext, clr_lo_en, long_move;
  logic [15:0] src_data;
  logic [31:0] long_data;
  logic [35:0] acc0_q, acc1_q;
  logic        busy, flag_n, flag_z, flag_v;

  int vectors = 0;
  int errors  = 0;
  logic [35:0] e0, e1;
  logic        en, ez, ev;

  always #2.5 clk = ~clk;

  acc_load_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .acc_sel(acc_sel),
    .half_sel(half_sel), .src_data(src_data), .src_narrow(src_narrow),
    .src_sext(src_sext), .clr_lo_en(clr_lo_en), .long_move(long_move),
    .long_data(long_data), .acc0_q(acc0_q), .acc1_q(acc1_q), .busy(busy),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " acc0"}, acc0_q, e0);
    chk({tag, " acc1"}, acc1_q, e1);
    chk({tag, " flags"}, {33'd0, flag_n, flag_z, flag_v}, {33'd0, en, ez, ev});
  endtask

  task automatic idle();
    cmd_valid = 0; long_move = 0; acc_sel = 0; half_sel = 0;
    src_data = '0; src_narrow = 0; src_sext = 0; clr_lo_en = 0; long_data = '0;
  endtask

  function automatic logic [15:0] widen(input logic [15:0] d, input logic nar, input logic sx);
    if (!nar) return d;
    return {{8{sx & d[7]}}, d[7:0]};
  endfunction

  function automatic logic [35:0] apply(input logic [35:0] a, input logic half,
                                        input logic [15:0] v, input logic clr);
    logic [35:0] r = a;
    if (half == 1'b0) begin
      r[31:16] = v;
      r[35:32] = {4{v[15]}};
      if (clr) r[15:0] = '0;
    end else begin
      r[15:0] = v;
    end
    return r;
  endfunction

  // Short move: drive, check busy after first edge, check result after second
  task automatic short_move(input string tag, input logic sel, input logic half,
                            input logic [15:0] d, input logic nar, input logic sx,
                            input logic clr);
    logic [15:0] v;
    @(negedge clk);
    cmd_valid = 1; long_move = 0; acc_sel = sel; half_sel = half;
    src_data = d; src_narrow = nar; src_sext = sx; clr_lo_en = clr;
    @(negedge clk);
    idle();
    chk({tag, " R7 busy"}, {35'd0, busy}, 36'd1);
    chk_state({tag, " R7 unchanged during busy"});
    v = widen(d, nar, sx);
    if (sel) e0 = apply(e0, half, v, clr); else e1 = apply(e1, half, v, clr);
    @(negedge clk);
    chk({tag, " R7 busy drop"}, {35'd0, busy}, 36'd0);
    chk_state(tag);
  endtask

  task automatic long_mv(input string tag, input logic sel, input logic [31:0] d,
                         input logic half);
    @(negedge clk);
    cmd_valid = 1; long_move = 1; acc_sel = sel; long_data = d;
    half_sel = half; clr_lo_en = 1; src_data = 16'hFFFF;
    @(negedge clk);
    idle();
    if (sel) e0 = {{4{d[31]}}, d}; else e1 = {{4{d[31]}}, d};
    en = d[31]; ez = (d == 0); ev = 1'b0;
    chk({tag, " R9 busy low"}, {35'd0, busy}, 36'd0);
    chk_state({tag, " R9 R10"});
  endtask

  task automatic t_reset();
    rst = 1; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    e0 = '0; e1 = '0; en = 0; ez = 0; ev = 0;
    chk("R1 busy", {35'd0, busy}, 36'd0);
    chk_state("R1 reset");
  endtask

  task automatic t_select();
    short_move("R2 a0 upper", 1'b1, 1'b0, 16'h1234, 0, 0, 0);
    short_move("R2 a1 lower", 1'b0, 1'b1, 16'hBEEF, 0, 0, 0);
  endtask

  task automatic t_upper_guard();
    short_move("R3 a1 upper neg keep low", 1'b0, 1'b0, 16'h8001, 0, 0, 0);
    short_move("R3 a1 upper pos", 1'b0, 1'b0, 16'h7FFF, 0, 0, 0);
  endtask

  task automatic t_clear();
    short_move("R4 a0 lower set", 1'b1, 1'b1, 16'hA5A5, 0, 0, 0);
    short_move("R4 a0 upper clr", 1'b1, 1'b0, 16'hC000, 0, 0, 1);
    short_move("R4 a0 lower clr ignored", 1'b1, 1'b1, 16'h0F0F, 0, 0, 1);
  endtask

  task automatic t_lower_keeps();
    short_move("R5 a1 upper neg", 1'b0, 1'b0, 16'hF00D, 0, 0, 0);
    short_move("R5 a1 lower", 1'b0, 1'b1, 16'h0000, 0, 0, 0);
  endtask

  task automatic t_narrow();
    short_move("R6 sext neg", 1'b1, 1'b1, 16'h3C85, 1, 1, 0);
    short_move("R6 zext neg", 1'b0, 1'b0, 16'h3C85, 1, 0, 0);
    short_move("R6 sext pos", 1'b1, 1'b0, 16'hFF42, 1, 1, 0);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    cmd_valid = 1; acc_sel = 1; half_sel = 1; src_data = 16'h1111;
    @(negedge clk);
    chk("R8 busy", {35'd0, busy}, 36'd1);
    acc_sel = 0; half_sel = 0; src_data = 16'h9999; clr_lo_en = 1;
    e0 = apply(e0, 1'b1, 16'h1111, 1'b0);
    @(negedge clk);
    idle();
    chk("R8 not re-armed", {35'd0, busy}, 36'd0);
    chk_state("R8 ignored");
    @(negedge clk);
    chk_state("R8 still ignored");
  endtask

  task automatic t_long();
    long_mv("long pos a0", 1'b1, 32'h1234_5678, 1'b1);
    long_mv("long neg a1", 1'b0, 32'h8000_0001, 1'b0);
    long_mv("long zero a0", 1'b1, 32'h0000_0000, 1'b0);
    short_move("R7 flags untouched", 1'b1, 1'b0, 16'h8000, 0, 0, 0);
    long_mv("long neg a0", 1'b1, 32'hFFFF_FFFF, 1'b1);
  endtask

  initial begin
    t_reset();
    t_select();
    t_upper_guard();
    t_clear();
    t_lower_keeps();
    t_narrow();
    t_busy_ignore();
    t_long();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule